// File: doc/BRIEF.md
# Pad-Ring Continuity Test Wrapper

This block sits between a chip's core and its digital pad ring so that a board tester can confirm that every pad is soldered to the board. When the active-low system reset is released, two bus straps are sampled: the LPC frame strobe and LPC data bit 0. The block then latches one of two modes, functional or continuity test. In functional mode the wrapper is transparent. Every pad carries the core's output value and output enable, and every pad level reaches the core.

In continuity test mode, every digital pad becomes an input and the core is cut off from the pads. The participating pads feed one chain of two-input XNOR stages, in ascending pad order. A single pad, normally the first serial port's transmit pad, is taken over to drive the chain result. The tester drives the pad inputs and watches that one pad. Inverting any participating pad's level toggles the result.

A parameter mask removes supply, ground and analog positions from the chain. The chain-output pad is always left out of the chain, and the reset pin is a separate port that never enters the chain.

Top module: `pad_continuity_wrap`

## Requirements
- R1: After power-up the block is in functional mode. While `sys_rst_n` is low the mode keeps its previous value, whatever the straps do.
- R2: Continuity test mode is entered when, at the first `clk` rising edge that samples `sys_rst_n` high after it was low, both `lpc_frame_n` and `lpc_data0` are low. The pad outputs reflect the new mode from that edge on.
- R3: At such a release edge, a high level on `lpc_frame_n` or on `lpc_data0` (either one suffices) selects functional mode, which also leaves a previously latched test mode.
- R4: While `sys_rst_n` stays high, the mode does not change when the straps change.
- R5: In test mode, `pad_oe` is 1 only at bit `CHAIN_OUT_PAD` and 0 at every other bit. Every other `pad_out` bit is 0.
- R6: In test mode, `pad_out[CHAIN_OUT_PAD]` equals a left-to-right fold r = ~(r ^ p) over the participating `pad_in` bits in ascending index order, seeded with the lowest one. A pad participates when its `CHAIN_MASK` bit is 1 and it is not `CHAIN_OUT_PAD`.
- R7: In test mode, inverting any single participating `pad_in` bit inverts `pad_out[CHAIN_OUT_PAD]` combinationally.
- R8: In test mode, `pad_in` bits whose mask bit is 0 and the bit at `CHAIN_OUT_PAD` have no effect on `pad_out[CHAIN_OUT_PAD]`.
- R9: In functional mode, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` (including bit `CHAIN_OUT_PAD`) and `core_in` equals `pad_in`.
- R10: In test mode, `core_in` is all zeros regardless of `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the reset release and the straps |
| sys_rst_n | input | 1 | Active-low system reset; its release latches the mode |
| lpc_frame_n | input | 1 | Frame strobe strap, sampled at reset release |
| lpc_data0 | input | 1 | Data bit 0 strap, sampled at reset release |
| pad_in | input | NUM_PADS | Levels received from the pads |
| core_out | input | NUM_PADS | Functional output values from the core |
| core_oe | input | NUM_PADS | Functional output enables from the core |
| core_in | output | NUM_PADS | Pad levels forwarded to the core (zero in test mode) |
| pad_out | output | NUM_PADS | Values sent to the pad drivers |
| pad_oe | output | NUM_PADS | Enables sent to the pad drivers |

## Verification
Two functions can fall in the same cycle: the mode decision at reset release, and the chain evaluation of new pad levels.

The bench drives the straps low and releases reset. In that same cycle it loads a fresh pad vector, and right after the sampling edge it raises both straps. It then judges two things at the following sample point. First, the mode must be test mode, set by the strap levels at the sampling edge and not by the later ones. Second, the chain output must already match the fold of the new vector.

A second case releases reset while straps are high and the pads change at the same time. The pads must then show the core's values and enables, with no trace of the chain.

// File: rtl/pad_continuity_pkg.sv
package pad_continuity_pkg;

   typedef enum logic {
      MODE_FUNCTIONAL = 1'b0,
      MODE_CONTINUITY = 1'b1
   } pad_mode_e;

   typedef enum logic [1:0] {
      CHAIN_CASCADE = 2'd0,
      CHAIN_TREE    = 2'd1
   } chain_style_e;

   function automatic pad_mode_e decode_straps(input logic frame_n, input logic data0);
      return (!frame_n && !data0) ? MODE_CONTINUITY : MODE_FUNCTIONAL;
   endfunction

endpackage

// File: rtl/pad_strap_latch.sv
module pad_strap_latch
   import pad_continuity_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_n,
   input  logic      data0,
   output pad_mode_e mode,
   output logic      release_seen
);

   logic      rst_seen_q = 1'b1;
   pad_mode_e mode_q     = MODE_FUNCTIONAL;

   assign release_seen = rst_n && !rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst_n;
   end

   always_ff @(posedge clk) begin
      if (release_seen) begin
         mode_q <= decode_straps(frame_n, data0);
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/pad_xnor_chain.sv
module pad_xnor_chain
   import pad_continuity_pkg::*;
#(
   parameter int                    NUM_PADS = 16,
   parameter logic [NUM_PADS-1:0]   MASK     = '1,
   parameter chain_style_e          STYLE    = CHAIN_CASCADE
) (
   input  logic [NUM_PADS-1:0] pads,
   output logic                result
);

   function automatic int pos_of(input int idx);
      int c;
      c = 0;
      for (int j = 0; j < idx; j++) begin
         if (MASK[j]) c++;
      end
      return c;
   endfunction

   localparam int NPART = pos_of(NUM_PADS);
   localparam logic TREE_INV = logic'((NPART - 1) % 2);

   if (NPART < 2) begin : g_bad_count
      $error("pad_xnor_chain: at least two participating pads are required");
   end

   logic [NPART-1:0] members;
   logic             unused_excluded;

   assign unused_excluded = ^(pads & ~MASK);

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pick
      if (MASK[i]) begin : g_in
         assign members[pos_of(i)] = pads[i];
      end
   end

   if (STYLE == CHAIN_CASCADE) begin : g_cascade
      logic [NPART-2:0] stage;
      assign stage[0] = ~(members[0] ^ members[1]);
      for (genvar k = 1; k < NPART - 1; k++) begin : g_stage
         assign stage[k] = ~(stage[k-1] ^ members[k+1]);
      end
      assign result = stage[NPART-2];
   end else begin : g_tree
      assign result = (^members) ^ TREE_INV;
   end

endmodule

// File: rtl/pad_mode_mux.sv
module pad_mode_mux
   import pad_continuity_pkg::*;
#(
   parameter int NUM_PADS      = 16,
   parameter int CHAIN_OUT_PAD = 0
) (
   input  pad_mode_e           mode,
   input  logic                chain_bit,
   input  logic [NUM_PADS-1:0] pad_in,
   input  logic [NUM_PADS-1:0] core_out,
   input  logic [NUM_PADS-1:0] core_oe,
   output logic [NUM_PADS-1:0] core_in,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe
);

   logic testing;
   assign testing = (mode == MODE_CONTINUITY);

   assign core_in = testing ? '0 : pad_in;

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      if (i == CHAIN_OUT_PAD) begin : g_tap
         assign pad_out[i] = testing ? chain_bit : core_out[i];
         assign pad_oe[i]  = testing ? 1'b1      : core_oe[i];
      end else begin : g_plain
         assign pad_out[i] = testing ? 1'b0 : core_out[i];
         assign pad_oe[i]  = testing ? 1'b0 : core_oe[i];
      end
   end

endmodule

// File: rtl/pad_continuity_wrap.sv
module pad_continuity_wrap
   import pad_continuity_pkg::*;
#(
   parameter int                  NUM_PADS      = 16,
   parameter int                  CHAIN_OUT_PAD = 5,
   parameter logic [NUM_PADS-1:0] CHAIN_MASK    = '1,
   parameter chain_style_e        CHAIN_STYLE   = CHAIN_CASCADE
) (
   input  logic                clk,
   input  logic                sys_rst_n,
   input  logic                lpc_frame_n,
   input  logic                lpc_data0,
   input  logic [NUM_PADS-1:0] pad_in,
   input  logic [NUM_PADS-1:0] core_out,
   input  logic [NUM_PADS-1:0] core_oe,
   output logic [NUM_PADS-1:0] core_in,
   output logic [NUM_PADS-1:0] pad_out,
   output logic [NUM_PADS-1:0] pad_oe
);

   localparam logic [NUM_PADS-1:0] OUT_BIT  = NUM_PADS'(1) << CHAIN_OUT_PAD;
   localparam logic [NUM_PADS-1:0] EFF_MASK = CHAIN_MASK & ~OUT_BIT;

   if (NUM_PADS < 3) begin : g_bad_width
      $error("pad_continuity_wrap: NUM_PADS must be at least 3");
   end
   if (CHAIN_OUT_PAD < 0 || CHAIN_OUT_PAD >= NUM_PADS) begin : g_bad_tap
      $error("pad_continuity_wrap: CHAIN_OUT_PAD out of range");
   end

   pad_mode_e mode;
   logic      release_seen;
   logic      chain_bit;

   pad_strap_latch u_latch (
      .clk          (clk),
      .rst_n        (sys_rst_n),
      .frame_n      (lpc_frame_n),
      .data0        (lpc_data0),
      .mode         (mode),
      .release_seen (release_seen)
   );

   pad_xnor_chain #(
      .NUM_PADS (NUM_PADS),
      .MASK     (EFF_MASK),
      .STYLE    (CHAIN_STYLE)
   ) u_chain (
      .pads   (pad_in),
      .result (chain_bit)
   );

   pad_mode_mux #(
      .NUM_PADS      (NUM_PADS),
      .CHAIN_OUT_PAD (CHAIN_OUT_PAD)
   ) u_mux (
      .mode      (mode),
      .chain_bit (chain_bit),
      .pad_in    (pad_in),
      .core_out  (core_out),
      .core_oe   (core_oe),
      .core_in   (core_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

endmodule

// File: rtl/pad_continuity_wrap_chk.sv
module pad_continuity_wrap_chk
   import pad_continuity_pkg::*;
#(
   parameter int                  NUM_PADS      = 16,
   parameter int                  CHAIN_OUT_PAD = 5,
   parameter logic [NUM_PADS-1:0] CHAIN_MASK    = '1
) (
   input logic                clk,
   input logic                sys_rst_n,
   input logic                lpc_frame_n,
   input logic                lpc_data0,
   input logic                release_seen,
   input pad_mode_e           mode,
   input logic [NUM_PADS-1:0] pad_in,
   input logic [NUM_PADS-1:0] core_out,
   input logic [NUM_PADS-1:0] core_oe,
   input logic [NUM_PADS-1:0] core_in,
   input logic [NUM_PADS-1:0] pad_out,
   input logic [NUM_PADS-1:0] pad_oe
);

   localparam logic [NUM_PADS-1:0] OUT_BIT  = NUM_PADS'(1) << CHAIN_OUT_PAD;
   localparam logic [NUM_PADS-1:0] EFF_MASK = CHAIN_MASK & ~OUT_BIT;
   localparam int                  NPART    = $countones(EFF_MASK);
   localparam logic                INV      = logic'((NPART - 1) % 2);

   logic ref_chain;
   assign ref_chain = (^(pad_in & EFF_MASK)) ^ INV;

   // R2
   a_r2_enter: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (release_seen && !lpc_frame_n && !lpc_data0) |=> (mode == MODE_CONTINUITY));

   // R3
   a_r3_leave: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (release_seen && (lpc_frame_n || lpc_data0)) |=> (mode == MODE_FUNCTIONAL));

   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !release_seen |=> $stable(mode));

   // R5
   a_r5_one_driver: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (mode == MODE_CONTINUITY) |-> (pad_oe == OUT_BIT && (pad_out & ~OUT_BIT) == '0));

   // R6
   a_r6_chain: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (mode == MODE_CONTINUITY) |-> (pad_out[CHAIN_OUT_PAD] == ref_chain));

   // R9
   a_r9_transparent: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (mode == MODE_FUNCTIONAL) |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

   // R10
   a_r10_core_cut: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (mode == MODE_CONTINUITY) |-> (core_in == '0));

endmodule

bind pad_continuity_wrap pad_continuity_wrap_chk #(
   .NUM_PADS      (NUM_PADS),
   .CHAIN_OUT_PAD (CHAIN_OUT_PAD),
   .CHAIN_MASK    (CHAIN_MASK)
) u_chk (
   .clk          (clk),
   .sys_rst_n    (sys_rst_n),
   .lpc_frame_n  (lpc_frame_n),
   .lpc_data0    (lpc_data0),
   .release_seen (release_seen),
   .mode         (mode),
   .pad_in       (pad_in),
   .core_out     (core_out),
   .core_oe      (core_oe),
   .core_in      (core_in),
   .pad_out      (pad_out),
   .pad_oe       (pad_oe)
);

// File: tb/pad_continuity_wrap_bench.sv
module pad_continuity_wrap_bench;

   localparam int               N    = 12;
   localparam int               TAP  = 4;
   localparam logic [N-1:0]     MASK = 12'hDF7;

   logic         clk = 1'b0;
   logic         sys_rst_n;
   logic         lpc_frame_n;
   logic         lpc_data0;
   logic [N-1:0] pad_in;
   logic [N-1:0] core_out;
   logic [N-1:0] core_oe;
   logic [N-1:0] core_in;
   logic [N-1:0] pad_out;
   logic [N-1:0] pad_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pad_continuity_wrap #(
      .NUM_PADS      (N),
      .CHAIN_OUT_PAD (TAP),
      .CHAIN_MASK    (MASK)
   ) u_pad_continuity_wrap (
      .clk         (clk),
      .sys_rst_n   (sys_rst_n),
      .lpc_frame_n (lpc_frame_n),
      .lpc_data0   (lpc_data0),
      .pad_in      (pad_in),
      .core_out    (core_out),
      .core_oe     (core_oe),
      .core_in     (core_in),
      .pad_out     (pad_out),
      .pad_oe      (pad_oe)
   );

   function automatic bit takes_part(input int i);
      return MASK[i] && (i != TAP);
   endfunction

   function automatic logic fold_ref(input logic [N-1:0] v);
      logic r;
      bit   first;
      r     = 1'b0;
      first = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (takes_part(i)) begin
            if (first) begin
               r     = v[i];
               first = 1'b0;
            end else begin
               r = ~(r ^ v[i]);
            end
         end
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic release_with(input logic fr, input logic d0);
      cyc();
      sys_rst_n   = 1'b0;
      cyc();
      cyc();
      lpc_frame_n = fr;
      lpc_data0   = d0;
      sys_rst_n   = 1'b1;
      cyc();
      settle();
   endtask

   task automatic t_reset_state();
      sys_rst_n = 1'b0; lpc_frame_n = 1'b0; lpc_data0 = 1'b0;
      pad_in = 12'h5A3; core_out = 12'h3C1; core_oe = 12'hF0F;
      settle();
      check(pad_oe == core_oe && pad_out == core_out, "R1 power-up functional", pad_oe, core_oe);
      repeat (4) cyc();
      settle();
      check(pad_oe == core_oe && core_in == pad_in, "R1 reset low keeps functional", pad_oe, core_oe);
   endtask

   task automatic t_enter();
      release_with(1'b0, 1'b0);
      check(pad_oe == (N'(1) << TAP), "R2 entered test mode", pad_oe, N'(1) << TAP);
      check(pad_oe == (N'(1) << TAP) && (pad_out & ~(N'(1) << TAP)) == '0,
            "R5 only tap drives", pad_out, '0);
   endtask

   task automatic t_chain_patterns();
      for (int n = 0; n < 20; n++) begin
         logic [N-1:0] v;
         logic         base;
         v = N'($urandom);
         if (n == 0) v = '0;
         if (n == 1) v = '1;
         pad_in = v;
         settle();
         base = fold_ref(v);
         check(pad_out[TAP] == base, "R6 chain value", pad_out[TAP], base);
         check(core_in == '0, "R10 core cut off", core_in, '0);
         for (int i = 0; i < N; i++) begin
            pad_in = v ^ (N'(1) << i);
            settle();
            if (takes_part(i))
               check(pad_out[TAP] == ~base, "R7 single flip toggles", pad_out[TAP], ~base);
            else
               check(pad_out[TAP] == base, "R8 excluded pad ignored", pad_out[TAP], base);
         end
         pad_in = v;
         cyc();
      end
   endtask

   task automatic t_hold();
      lpc_frame_n = 1'b1; lpc_data0 = 1'b1;
      repeat (3) cyc();
      lpc_frame_n = 1'b0;
      repeat (2) cyc();
      settle();
      check(pad_oe == (N'(1) << TAP), "R4 straps ignored while running", pad_oe, N'(1) << TAP);
   endtask

   task automatic t_exit(input logic fr, input logic d0, input string tag);
      cyc();
      sys_rst_n = 1'b0;
      lpc_frame_n = fr; lpc_data0 = d0;
      repeat (3) cyc();
      settle();
      check(pad_oe == (N'(1) << TAP), "R1 mode kept while reset low", pad_oe, N'(1) << TAP);
      sys_rst_n = 1'b1;
      cyc();
      settle();
      check(pad_oe == core_oe, tag, pad_oe, core_oe);
      for (int n = 0; n < 4; n++) begin
         pad_in = N'($urandom); core_out = N'($urandom); core_oe = N'($urandom);
         settle();
         check(pad_out == core_out && pad_oe == core_oe && core_in == pad_in,
               "R9 functional pass-through", pad_out, core_out);
      end
   endtask

   task automatic t_same_cycle();
      logic [N-1:0] v;
      cyc();
      sys_rst_n = 1'b0;
      cyc();
      lpc_frame_n = 1'b0; lpc_data0 = 1'b0;
      v = 12'hA6D;
      pad_in = v;
      sys_rst_n = 1'b1;
      @(posedge clk);
      #1;
      lpc_frame_n = 1'b1; lpc_data0 = 1'b1;
      cyc();
      settle();
      check(pad_oe == (N'(1) << TAP), "R2 edge-sampled straps win", pad_oe, N'(1) << TAP);
      check(pad_out[TAP] == fold_ref(v), "R6 chain on release cycle", pad_out[TAP], fold_ref(v));
      // leave with straps high while pads change in the release cycle
      cyc();
      sys_rst_n = 1'b0;
      cyc();
      sys_rst_n = 1'b1; pad_in = 12'h1F0; core_out = 12'h0AA; core_oe = 12'h555;
      cyc();
      settle();
      check(pad_out == core_out && pad_oe == core_oe, "R3 exit with pad change", pad_oe, core_oe);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      t_reset_state();
      t_enter();
      t_chain_patterns();
      t_hold();
      t_exit(1'b1, 1'b0, "R3 frame high leaves test");
      release_with(1'b0, 1'b0);
      check(pad_oe == (N'(1) << TAP), "R2 re-entered test mode", pad_oe, N'(1) << TAP);
      t_exit(1'b0, 1'b1, "R3 data0 high leaves test");
      t_same_cycle();
      finish_run();
   end

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

endmodule